// File: doc/BRIEF.md
# Four-Phase Host Bus Access Sequencer

This block sits between a host processor bus and an internal register file. On every rising edge of the system clock it samples an active-low chip select, a write/read-not line, an interrupt-acknowledge line and an address. When it sees chip select low, it runs one access through four fixed clock phases, P1 to P4. It sends a read strobe or a write strobe to the register file in a fixed phase. It drives read data back onto the host bus and tells the bus pads which way to point. It pulls an active-low data acknowledge in the final phase.

A mode input selects how the sequencer behaves while chip select stays low:

- **Single mode:** it performs exactly one access and then waits for chip select to go high again.
- **Burst mode:** it starts a fresh access every four clocks.

Releasing chip select kills any access in progress at once. Address bit 6 is forced to zero. Address bit 7 tells the register file whether the access targets the data region (FIFOs) or the control region.

Top module: `hostbus_seq`

## Requirements
- R1: An access occupies exactly four clock cycles. Counting the first cycle after the edge that samples chip select low as cycle 1, the acknowledge appears in cycle 4. In burst mode it then appears again in cycles 8, 12 and so on.
- R2: `ack_n` is low only during phase P4 of a live access. It is low for a single cycle per access.
- R3: With `burst_en` low, holding chip select low for any length of time yields exactly one access. A new access needs chip select to go high and then low again.
- R4: With `burst_en` high, chip select held low starts a new access every four clocks. Each access re-samples the address and the direction.
- R5: If chip select goes high before P4, the access is abandoned at once. There is no further write strobe, no acknowledge, and the data bus is released. The sequencer returns to idle on the next edge.
- R6: `wr_rd_n` high selects a write and low selects a read. A write raises `reg_wr` for exactly one cycle, in P3, and only if chip select is still low. `reg_wdata` follows `host_din`.
- R7: A read raises `reg_rd` in P1. The value of `reg_rdata` at the end of P1 is held on `host_dout` with `host_doe` high from P2 through P4. `host_doe` is low in the cycle after P4, even if chip select stays low.
- R8: `reg_addr` carries the address captured at the start of the access with bit 6 forced to 0. `reg_region` equals captured address bit 7 (1 = data region, 0 = control region).
- R9: While `iack_n` is low, a low chip select starts no access.
- R10: `rst_n` is a synchronous active-low reset. It returns the sequencer to idle with `ack_n` high, `host_doe` low and no strobes. This holds even in the middle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| burst_en | input | 1 | 1 = burst mode, 0 = single mode |
| cs_n | input | 1 | Chip select, active low |
| wr_rd_n | input | 1 | 1 = write, 0 = read |
| iack_n | input | 1 | Interrupt acknowledge cycle in progress, active low |
| addr | input | AW | Host address |
| host_din | input | DW | Write data from the host bus |
| host_dout | output | DW | Read data toward the host bus |
| host_doe | output | 1 | Drive enable for the host data bus |
| ack_n | output | 1 | Data acknowledge, active low |
| reg_addr | output | AW | Register file address, bit 6 cleared |
| reg_region | output | 1 | 1 = data region, 0 = control region |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_wdata | output | DW | Register write data |
| reg_rdata | input | DW | Register read data |

## Verification
Inputs change on the falling clock edge. Results are sampled a quarter period after each rising edge. If chip select falls before rising edge E0, the following results are due:

| Result | Due after edge |
|---|---|
| Read strobe | E0 |
| Read data on the bus | E1 to E3 |
| Write strobe | E2 |
| Acknowledge | E3 |

The monitor counts sampled cycles since chip select fell and requires every acknowledge to land on a multiple of four. It compares address, region and data against the queued expectation at that moment.

Abort, reset, interrupt-acknowledge and single-mode hold cases are judged over a fixed window of cycles afterwards. The judgement uses the changes in the acknowledge, strobe and drive-enable counts over that window.

// File: rtl/hostbus_seq.sv
module hostbus_seq #(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int SEL_BIT  = 7,
  parameter int DEAD_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          burst_en,
  input  logic          cs_n,
  input  logic          wr_rd_n,
  input  logic          iack_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  output logic          host_doe,
  output logic          ack_n,
  output logic [AW-1:0] reg_addr,
  output logic          reg_region,
  output logic          reg_wr,
  output logic          reg_rd,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata
);

  typedef enum logic [2:0] {IDLE, P1, P2, P3, P4} ph_t;

  localparam logic [AW-1:0] KEEP = ~(AW'(1) << DEAD_BIT);

  ph_t           ph;
  logic          hold;
  logic          w_q;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic          live;
  logic [AW-1:0] a_in;

  assign live = ~cs_n;
  assign a_in = addr & KEEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= IDLE;
      hold <= 1'b0;
      w_q  <= 1'b0;
      a_q  <= '0;
      d_q  <= '0;
    end else if (cs_n) begin
      ph   <= IDLE;
      hold <= 1'b0;
    end else begin
      case (ph)
        IDLE: if (!hold && iack_n) begin
          ph  <= P1;
          a_q <= a_in;
          w_q <= wr_rd_n;
        end
        P1: begin
          ph <= P2;
          if (!w_q) d_q <= reg_rdata;
        end
        P2: ph <= P3;
        P3: ph <= P4;
        P4: if (burst_en) begin
          ph  <= P1;
          a_q <= a_in;
          w_q <= wr_rd_n;
        end else begin
          ph   <= IDLE;
          hold <= 1'b1;
        end
        default: ph <= IDLE;
      endcase
    end
  end

  assign ack_n      = ~(live && ph == P4);
  assign reg_wr     = live && ph == P3 && w_q;
  assign reg_rd     = live && ph == P1 && !w_q;
  assign host_doe   = live && !w_q && (ph == P2 || ph == P3 || ph == P4);
  assign host_dout  = d_q;
  assign reg_addr   = a_q;
  assign reg_region = a_q[SEL_BIT];
  assign reg_wdata  = host_din;

endmodule

// File: rtl/hostbus_seq_chk.sv
module hostbus_seq_chk #(
  parameter int AW       = 8,
  parameter int DEAD_BIT = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          ack_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic          host_doe,
  input logic [AW-1:0] reg_addr
);

  // R1
  ack_after_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> ($past(!cs_n, 1) && $past(!cs_n, 2) && $past(!cs_n, 3)));

  // R2
  ack_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> !cs_n);

  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |=> ack_n);

  // R5
  release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (ack_n && !reg_wr && !reg_rd && !host_doe));

  // R6
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R6
  wr_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (!ack_n || cs_n));

  // R7
  doe_not_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_doe |-> (!cs_n && !reg_wr));

  // R8
  addr_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> !reg_addr[DEAD_BIT]);

  // R10
  reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (ack_n && !host_doe && !reg_wr));

endmodule

bind hostbus_seq hostbus_seq_chk #(.AW(AW), .DEAD_BIT(DEAD_BIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ack_n(ack_n), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .host_doe(host_doe), .reg_addr(reg_addr)
);

// File: tb/hostbus_seq_test.sv
module hostbus_seq_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic       rst_n = 1'b0, burst_en = 1'b0, cs_n = 1'b1, wr_rd_n = 1'b0, iack_n = 1'b1;
  logic [7:0] addr = '0, host_din = '0, rd_val = '0;
  logic [7:0] host_dout, reg_addr, reg_wdata;
  logic       host_doe, ack_n, reg_region, reg_wr, reg_rd;

  hostbus_seq uut (
    .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .cs_n(cs_n), .wr_rd_n(wr_rd_n),
    .iack_n(iack_n), .addr(addr), .host_din(host_din), .host_dout(host_dout),
    .host_doe(host_doe), .ack_n(ack_n), .reg_addr(reg_addr), .reg_region(reg_region),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(rd_val)
  );

  typedef struct { bit wr; logic [7:0] adr; logic [7:0] dat; } exp_t;
  exp_t sbq[$];
  exp_t cur;

  int n_chk = 0, n_fail = 0;
  int acks = 0, wrs = 0, doecyc = 0, run = 0;
  bit seen_wr = 0;
  logic [7:0] wr_a, wr_d;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    #(PERIOD/4);
    if (!rst_n || cs_n) run = 0; else run++;
    if (host_doe) doecyc++;
    if (reg_wr) begin
      wrs++; seen_wr = 1; wr_a = reg_addr; wr_d = reg_wdata;
    end
    if (!ack_n) begin
      acks++;
      chk(run > 0 && run % 4 == 0, "R1 ack cycle", run, ((run + 3) / 4) * 4);
      if (sbq.size() == 0) chk(0, "R2 unexpected ack", 1, 0);
      else begin
        cur = sbq.pop_front();
        chk(reg_addr == cur.adr, "R8 reg_addr", reg_addr, cur.adr);
        chk(reg_region == cur.adr[7], "R8 region", reg_region, cur.adr[7]);
        if (cur.wr) begin
          chk(seen_wr, "R6 write strobe seen", seen_wr, 1);
          chk(wr_a == cur.adr && wr_d == cur.dat, "R6 write data", wr_d, cur.dat);
        end else begin
          chk(host_doe, "R7 doe at P4", host_doe, 1);
          chk(host_dout == cur.dat, "R7 read data", host_dout, cur.dat);
        end
        seen_wr = 0;
      end
    end
  end

  task automatic go(bit wr, logic [7:0] a, logic [7:0] d, int hold);
    @(negedge clk);
    wr_rd_n = wr; addr = a;
    if (wr) host_din = d; else rd_val = d;
    sbq.push_back('{wr, a & 8'hBF, d});
    cs_n = 1'b0;
    repeat (hold) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int a0, w0, d0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(ack_n == 1, "R10 ack_n in reset", ack_n, 1);
    chk(host_doe == 0, "R10 doe in reset", host_doe, 0);
    chk(reg_wr == 0 && reg_rd == 0, "R10 strobes in reset", reg_wr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 R8 single-mode writes, both regions, bit 6 set
    go(1, 8'h85, 8'h3C, 4);
    go(1, 8'h12, 8'hA5, 4);
    go(1, 8'h5A, 8'h0F, 4);
    go(1, 8'hC3, 8'hF0, 4);
    // R7 R8 reads
    go(0, 8'h81, 8'h77, 4);
    go(0, 8'h4E, 8'h19, 4);

    // R3 R7 single mode hold: one access, three drive cycles, released after P4
    a0 = acks; w0 = wrs; d0 = doecyc;
    go(0, 8'h20, 8'hCE, 16);
    chk(acks - a0 == 1, "R3 one ack per assertion", acks - a0, 1);
    chk(doecyc - d0 == 3, "R7 drive cycles P2..P4", doecyc - d0, 3);
    a0 = acks; w0 = wrs;
    go(1, 8'h91, 8'h55, 16);
    chk(acks - a0 == 1, "R3 one ack on long write", acks - a0, 1);
    chk(wrs - w0 == 1, "R3 one write strobe", wrs - w0, 1);

    // R4 burst writes: three accesses in twelve cycles
    burst_en = 1'b1;
    a0 = acks; w0 = wrs;
    @(negedge clk);
    wr_rd_n = 1'b1; addr = 8'h84; host_din = 8'h6B;
    for (int i = 0; i < 3; i++) sbq.push_back('{1'b1, 8'h84, 8'h6B});
    cs_n = 1'b0;
    repeat (12) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    chk(acks - a0 == 3, "R4 burst write acks", acks - a0, 3);
    chk(wrs - w0 == 3, "R4 burst write strobes", wrs - w0, 3);

    // R4 burst reads with address change between accesses
    a0 = acks; d0 = doecyc;
    @(negedge clk);
    wr_rd_n = 1'b0; addr = 8'h03; rd_val = 8'hD2;
    sbq.push_back('{1'b0, 8'h03, 8'hD2});
    sbq.push_back('{1'b0, 8'h83, 8'hD2});
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    addr = 8'hC3;
    repeat (5) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    chk(acks - a0 == 2, "R4 burst read acks", acks - a0, 2);
    chk(doecyc - d0 == 6, "R4 burst read drive cycles", doecyc - d0, 6);
    burst_en = 1'b0;

    // R5 abort during P2: write
    a0 = acks; w0 = wrs;
    @(negedge clk);
    wr_rd_n = 1'b1; addr = 8'h11; cs_n = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(acks - a0 == 0, "R5 abort no ack", acks - a0, 0);
    chk(wrs - w0 == 0, "R5 abort no write", wrs - w0, 0);
    chk(host_doe == 0, "R5 bus released", host_doe, 0);
    // R5 abort during P3 read
    a0 = acks; d0 = doecyc;
    @(negedge clk);
    wr_rd_n = 1'b0; cs_n = 1'b0;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(acks - a0 == 0, "R5 read abort no ack", acks - a0, 0);
    chk(doecyc - d0 == 2, "R5 read abort drive cycles", doecyc - d0, 2);

    // R9 chip select during interrupt acknowledge
    a0 = acks; w0 = wrs;
    @(negedge clk);
    iack_n = 1'b0; wr_rd_n = 1'b1; cs_n = 1'b0;
    repeat (8) @(negedge clk);
    cs_n = 1'b1; iack_n = 1'b1;
    @(negedge clk);
    chk(acks - a0 == 0, "R9 no access in iack", acks - a0, 0);
    chk(wrs - w0 == 0, "R9 no write in iack", wrs - w0, 0);

    // R10 reset mid-access
    a0 = acks; w0 = wrs;
    @(negedge clk);
    wr_rd_n = 1'b1; cs_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(acks - a0 == 0, "R10 reset kills ack", acks - a0, 0);
    chk(wrs - w0 == 0, "R10 reset kills write", wrs - w0, 0);

    // R2 after reset, normal access still works
    go(1, 8'h8F, 8'h42, 4);
    repeat (2) @(negedge clk);
    chk(sbq.size() == 0, "R2 every expected ack seen", sbq.size(), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule